// File: doc/BRIEF.md
# Two-Level I/O Address Translation Walker

This block turns a 32-bit I/O virtual address (IOVA) into a physical address by reading a two-level translation table from memory. A client hands it one request, made of the IOVA and the address of the first-level table. The walker reads the first-level word over a single-outstanding read port with a valid/ready request channel. That word either maps a 1 MiB region directly, points to a second-level table, or marks a fault. When it points to a second-level table, the walker makes a second read and decodes that entry as a 64 KiB page, a 4 KiB page or a fault.

The result goes back on a response channel with valid/ready handshake. It carries the physical address, a page size code and a fault flag, and echoes the IOVA. The walker is strictly one request at a time. It becomes ready again only once the response has been taken. It never writes memory and keeps no cache of earlier walks.

States: `ST_IDLE` (ready for a request), `ST_L1_ISSUE` (first-level read presented), `ST_L1_WAIT` (waiting for first-level data), `ST_L2_ISSUE` (second-level read presented), `ST_L2_WAIT` (waiting for second-level data), `ST_REPLY` (response presented). Transitions: IDLE→L1_ISSUE on an accepted request. L1_ISSUE→L1_WAIT when the read is accepted. L1_WAIT→REPLY on section or fault data, and L1_WAIT→L2_ISSUE on a table pointer. L2_ISSUE→L2_WAIT when the read is accepted. L2_WAIT→REPLY on any data. REPLY→IDLE when the response is taken.

Top module: `iova_table_walker`

## Requirements
- R1: After reset the walker is idle: `req_ready` is 1 and both `mem_req_valid` and `rsp_valid` are 0.
- R2: The first read goes to `req_base + 4 * iova[31:20]`, computed with a full 32-bit add.
- R3: A first-level word whose bits [1:0] are 2 ends the walk after one read. The response has physical address {word[31:20], iova[19:0]} and size code 3 (1 MiB).
- R4: A first-level word whose bits [1:0] are 1 causes a second read at {word[31:10], iova[19:12], 2'b00}.
- R5: A first-level word whose bits [1:0] are 0 or 3 ends the walk after one read with a fault. The fault flag is 1, the size code is 0, the physical address is 0 and `rsp_iova` is the request IOVA.
- R6: A second-level word whose bits [1:0] are 1 gives physical address {word[31:16], iova[15:0]} and size code 2 (64 KiB). A 64 KiB page is stored as 16 equal words, so any of its 16 slots translates the same way.
- R7: A second-level word with bit 1 set (bits [1:0] equal to 2 or 3) gives physical address {word[31:12], iova[11:0]} and size code 1 (4 KiB).
- R8: A second-level word whose bits [1:0] are 0 gives a fault. The fault flag is 1, the size code is 0 and the physical address is 0.
- R9: From the accepted request until the response handshake, `req_ready` stays 0. While `rsp_valid` is 1 and `rsp_ready` is 0, every response field holds steady.
- R10: A read request, once presented, stays valid with a steady address until `mem_req_ready` is 1. At most one read is outstanding.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker can take a request |
| req_iova | input | 32 | Address to translate |
| req_base | input | 32 | First-level table address |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory takes the read |
| mem_req_addr | output | 32 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data word |
| rsp_valid | output | 1 | Result valid |
| rsp_ready | input | 1 | Client takes the result |
| rsp_fault | output | 1 | Translation fault |
| rsp_size | output | 2 | 0 fault, 1 4 KiB, 2 64 KiB, 3 1 MiB |
| rsp_iova | output | 32 | Echo of the translated IOVA |
| rsp_pa | output | 32 | Physical address (0 on fault) |

## Verification
The assertions assume that memory returns read data only for a read it has accepted, and exactly once per read. The walker samples `mem_rsp_valid` only in its wait states. The bench memory model follows this rule. It answers every accepted read with a fixed two-cycle delay and returns zero for unpopulated addresses. Request and response handshakes are driven on the falling edge. Memory back-pressure is produced by a periodic ready pattern, so the hold rules are exercised without breaking the one-read-at-a-time contract.

// File: rtl/pgw_pkg.sv
package pgw_pkg;
    localparam int ADDR_W      = 32;
    localparam int L1_IDX_LSB  = 20;
    localparam int L2_IDX_LSB  = 12;
    localparam int LARGE_SHIFT = 16;
    localparam int L2_BASE_LSB = 10;
    localparam int L1_IDX_W    = ADDR_W - L1_IDX_LSB;
    localparam int L2_IDX_W    = L1_IDX_LSB - L2_IDX_LSB;

    typedef enum logic [1:0] {
        SZ_NONE = 2'd0,
        SZ_4K   = 2'd1,
        SZ_64K  = 2'd2,
        SZ_1M   = 2'd3
    } pg_size_e;

    typedef enum logic [1:0] {
        L1K_FAULT = 2'd0,
        L1K_TABLE = 2'd1,
        L1K_SECT  = 2'd2
    } l1_kind_e;
endpackage

// File: rtl/pgw_l1_decode.sv
module pgw_l1_decode
    import pgw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] iova,
    output l1_kind_e          kind,
    output logic [ADDR_W-1:0] sect_pa,
    output logic [ADDR_W-1:0] l2_addr
);
    logic unused_bits;
    assign unused_bits = ^{entry[L2_BASE_LSB-1:2], iova[L2_IDX_LSB-1:0]};

    always_comb begin
        unique case (entry[1:0])
            2'd1:    kind = L1K_TABLE;
            2'd2:    kind = L1K_SECT;
            default: kind = L1K_FAULT;
        endcase
    end

    assign sect_pa = {entry[ADDR_W-1:L1_IDX_LSB], iova[L1_IDX_LSB-1:0]};
    assign l2_addr = {entry[ADDR_W-1:L2_BASE_LSB], iova[L1_IDX_LSB-1:L2_IDX_LSB], 2'b00};
endmodule

// File: rtl/pgw_l2_decode.sv
module pgw_l2_decode
    import pgw_pkg::*;
(
    input  logic [ADDR_W-1:0] entry,
    input  logic [ADDR_W-1:0] iova,
    output pg_size_e          size,
    output logic [ADDR_W-1:0] pa
);
    logic unused_bits;
    assign unused_bits = ^{entry[L2_IDX_LSB-1:2], iova[ADDR_W-1:LARGE_SHIFT]};

    always_comb begin
        size = SZ_NONE;
        pa   = '0;
        if (entry[1]) begin
            size = SZ_4K;
            pa   = {entry[ADDR_W-1:L2_IDX_LSB], iova[L2_IDX_LSB-1:0]};
        end else if (entry[0]) begin
            size = SZ_64K;
            pa   = {entry[ADDR_W-1:LARGE_SHIFT], iova[LARGE_SHIFT-1:0]};
        end
    end
endmodule

// File: rtl/iova_table_walker.sv
module iova_table_walker
    import pgw_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_iova,
    input  logic [ADDR_W-1:0] req_base,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic [ADDR_W-1:0] mem_req_addr,
    input  logic              mem_rsp_valid,
    input  logic [ADDR_W-1:0] mem_rsp_data,
    output logic              rsp_valid,
    input  logic              rsp_ready,
    output logic              rsp_fault,
    output logic [1:0]        rsp_size,
    output logic [ADDR_W-1:0] rsp_iova,
    output logic [ADDR_W-1:0] rsp_pa
);
    typedef enum logic [2:0] {
        ST_IDLE, ST_L1_ISSUE, ST_L1_WAIT, ST_L2_ISSUE, ST_L2_WAIT, ST_REPLY
    } walk_st_e;

    walk_st_e          state, state_n;
    logic [ADDR_W-1:0] iova_q, base_q, l2_addr_q, pa_q;
    pg_size_e          size_q;
    logic              fault_q;
    logic [ADDR_W-1:0] l1_addr;

    l1_kind_e          l1_kind;
    logic [ADDR_W-1:0] l1_sect_pa, l1_next;
    pg_size_e          l2_size;
    logic [ADDR_W-1:0] l2_pa;

    pgw_l1_decode u_l1 (
        .entry(mem_rsp_data), .iova(iova_q),
        .kind(l1_kind), .sect_pa(l1_sect_pa), .l2_addr(l1_next)
    );

    pgw_l2_decode u_l2 (
        .entry(mem_rsp_data), .iova(iova_q),
        .size(l2_size), .pa(l2_pa)
    );

    assign l1_addr = base_q + {{(ADDR_W-L1_IDX_W-2){1'b0}}, iova_q[ADDR_W-1:L1_IDX_LSB], 2'b00};

    // next state
    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:     if (req_valid) state_n = ST_L1_ISSUE;
            ST_L1_ISSUE: if (mem_req_ready) state_n = ST_L1_WAIT;
            ST_L1_WAIT:  if (mem_rsp_valid)
                             state_n = (l1_kind == L1K_TABLE) ? ST_L2_ISSUE : ST_REPLY;
            ST_L2_ISSUE: if (mem_req_ready) state_n = ST_L2_WAIT;
            ST_L2_WAIT:  if (mem_rsp_valid) state_n = ST_REPLY;
            ST_REPLY:    if (rsp_ready) state_n = ST_IDLE;
            default:     state_n = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_n;
    end

    // captured walk data and result
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iova_q    <= '0;
            base_q    <= '0;
            l2_addr_q <= '0;
            pa_q      <= '0;
            size_q    <= SZ_NONE;
            fault_q   <= 1'b0;
        end else begin
            unique case (state)
                ST_IDLE: if (req_valid) begin
                    iova_q <= req_iova;
                    base_q <= req_base;
                end
                ST_L1_WAIT: if (mem_rsp_valid) begin
                    unique case (l1_kind)
                        L1K_SECT: begin
                            pa_q <= l1_sect_pa; size_q <= SZ_1M; fault_q <= 1'b0;
                        end
                        L1K_TABLE: l2_addr_q <= l1_next;
                        default: begin
                            pa_q <= '0; size_q <= SZ_NONE; fault_q <= 1'b1;
                        end
                    endcase
                end
                ST_L2_WAIT: if (mem_rsp_valid) begin
                    pa_q    <= l2_pa;
                    size_q  <= l2_size;
                    fault_q <= (l2_size == SZ_NONE);
                end
                default: ;
            endcase
        end
    end

    // outputs
    always_comb begin
        req_ready     = (state == ST_IDLE);
        mem_req_valid = (state == ST_L1_ISSUE) || (state == ST_L2_ISSUE);
        mem_req_addr  = (state == ST_L2_ISSUE) ? l2_addr_q : l1_addr;
        rsp_valid     = (state == ST_REPLY);
        rsp_fault     = fault_q;
        rsp_size      = size_q;
        rsp_iova      = iova_q;
        rsp_pa        = pa_q;
    end

    // checks
    a_r1_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req_valid && !rsp_valid));

    a_r9_busy_until_taken: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    a_r9_rsp_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_ready) |=>
            (rsp_valid && $stable(rsp_pa) && $stable(rsp_size) &&
             $stable(rsp_fault) && $stable(rsp_iova)));

    a_r10_read_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));

    a_r10_single_read: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_ready) |=> !mem_req_valid);

    a_r5_fault_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_fault) |-> (rsp_pa == '0 && rsp_size == 2'd0));

    a_r3_size_nonzero: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_fault) |-> (rsp_size != 2'd0));

    a_r4_l2_index: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_L2_ISSUE) |->
            (mem_req_addr[1:0] == 2'b00 &&
             mem_req_addr[L2_BASE_LSB-1:2] == rsp_iova[L1_IDX_LSB-1:L2_IDX_LSB]));
endmodule

// File: tb/iova_table_walker_tb_top.sv
module iova_table_walker_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [31:0] req_iova = '0;
    logic [31:0] req_base = '0;
    logic        mem_req_valid;
    logic        mem_req_ready;
    logic [31:0] mem_req_addr;
    logic        mem_rsp_valid = 1'b0;
    logic [31:0] mem_rsp_data = '0;
    logic        rsp_valid;
    logic        rsp_ready = 1'b0;
    logic        rsp_fault;
    logic [1:0]  rsp_size;
    logic [31:0] rsp_iova;
    logic [31:0] rsp_pa;

    int n_chk = 0;
    int n_bad = 0;
    int cycles = 0;

    always #5 clk = ~clk;

    iova_table_walker dut_i (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready),
        .req_iova(req_iova), .req_base(req_base),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_addr(mem_req_addr),
        .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
        .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
        .rsp_fault(rsp_fault), .rsp_size(rsp_size),
        .rsp_iova(rsp_iova), .rsp_pa(rsp_pa)
    );

    // memory model: two-cycle read latency, optional request back-pressure
    logic [31:0] mem_tbl [logic [31:0]];
    logic        stall_en = 1'b0;
    logic [1:0]  stall_cnt = '0;
    logic        p_valid = 1'b0;
    logic [31:0] p_addr = '0;
    int          rd_total = 0;
    logic [31:0] rd_log [0:15];

    function automatic logic [31:0] rd_word(input logic [31:0] a);
        if (mem_tbl.exists(a)) return mem_tbl[a];
        return 32'h0;
    endfunction

    assign mem_req_ready = stall_en ? (stall_cnt == 2'd3) : 1'b1;

    always @(posedge clk) begin
        stall_cnt     <= stall_cnt + 2'd1;
        p_valid       <= mem_req_valid && mem_req_ready;
        p_addr        <= mem_req_addr;
        mem_rsp_valid <= p_valid;
        mem_rsp_data  <= rd_word(p_addr);
        if (mem_req_valid && mem_req_ready) begin
            rd_log[rd_total[3:0]] <= mem_req_addr;
            rd_total <= rd_total + 1;
        end
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 100000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog expired act=%0d exp=<100000", cycles);
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk = n_chk + 1;
        if (act !== exp) begin
            n_bad = n_bad + 1;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // one full translation; hold = cycles rsp_ready is kept low
    task automatic walk(input logic [31:0] iova, input logic [31:0] base, input int hold,
                        output logic [31:0] pa, output logic [1:0] sz,
                        output logic flt, output logic [31:0] echo, output int nrd);
        int start;
        int t;
        @(negedge clk);
        start = rd_total;
        req_iova  = iova;
        req_base  = base;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        chk("R9 busy after accept", {31'b0, req_ready}, 32'd0);
        t = 0;
        while (!rsp_valid && t < 200) begin
            @(negedge clk);
            t++;
        end
        chk("R9 response arrives", {31'b0, rsp_valid}, 32'd1);
        pa = rsp_pa; sz = rsp_size; flt = rsp_fault; echo = rsp_iova;
        for (int i = 0; i < hold; i++) begin
            req_valid = 1'b1;
            @(negedge clk);
            chk("R9 hold valid", {31'b0, rsp_valid}, 32'd1);
            chk("R9 hold pa", rsp_pa, pa);
            chk("R9 hold size", {30'b0, rsp_size}, {30'b0, sz});
            chk("R9 no accept while busy", {31'b0, req_ready}, 32'd0);
        end
        req_valid = 1'b0;
        rsp_ready = 1'b1;
        @(negedge clk);
        rsp_ready = 1'b0;
        chk("R9 ready after handshake", {31'b0, req_ready}, 32'd1);
        nrd = rd_total - start;
    endtask

    task automatic t_reset();
        chk("R1 req_ready", {31'b0, req_ready}, 32'd1);
        chk("R1 mem_req_valid", {31'b0, mem_req_valid}, 32'd0);
        chk("R1 rsp_valid", {31'b0, rsp_valid}, 32'd0);
    endtask

    task automatic t_section();
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(32'h1234_5678, 32'h4000_0000, 0, pa, sz, f, echo, n);
        chk("R2 first read addr", rd_log[(rd_total-1) & 15], 32'h4000_048C);
        chk("R3 section pa", pa, 32'hABC4_5678);
        chk("R3 section size", {30'b0, sz}, 32'd3);
        chk("R3 no fault", {31'b0, f}, 32'd0);
        chk("R3 one read", n, 32'd1);
    endtask

    task automatic t_base_add();
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(32'hFFF0_0ABC, 32'h1000_0010, 0, pa, sz, f, echo, n);
        chk("R2 top index with offset base", rd_log[(rd_total-1) & 15], 32'h1000_400C);
        chk("R3 section pa top", pa, 32'hFED0_0ABC);
    endtask

    task automatic t_l1_fault(input logic [31:0] iova, input string tag);
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(iova, 32'h4000_0000, 0, pa, sz, f, echo, n);
        chk({"R5 fault flag ", tag}, {31'b0, f}, 32'd1);
        chk({"R5 fault size ", tag}, {30'b0, sz}, 32'd0);
        chk({"R5 fault pa ", tag}, pa, 32'd0);
        chk({"R5 fault iova ", tag}, echo, iova);
        chk({"R5 single read ", tag}, n, 32'd1);
    endtask

    task automatic t_large(input logic [31:0] iova, input logic [31:0] l2a, input logic [31:0] exp_pa);
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(iova, 32'h4000_0000, 0, pa, sz, f, echo, n);
        chk("R4 two reads", n, 32'd2);
        chk("R4 second read addr", rd_log[(rd_total-1) & 15], l2a);
        chk("R6 large pa", pa, exp_pa);
        chk("R6 large size", {30'b0, sz}, 32'd2);
        chk("R6 no fault", {31'b0, f}, 32'd0);
    endtask

    task automatic t_small(input logic [31:0] iova, input logic [31:0] exp_pa);
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(iova, 32'h4000_0000, 0, pa, sz, f, echo, n);
        chk("R7 small pa", pa, exp_pa);
        chk("R7 small size", {30'b0, sz}, 32'd1);
        chk("R7 no fault", {31'b0, f}, 32'd0);
    endtask

    task automatic t_l2_fault();
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        walk(32'h0072_3456, 32'h4000_0000, 0, pa, sz, f, echo, n);
        chk("R8 fault flag", {31'b0, f}, 32'd1);
        chk("R8 size zero", {30'b0, sz}, 32'd0);
        chk("R8 pa zero", pa, 32'd0);
        chk("R8 two reads", n, 32'd2);
    endtask

    task automatic t_backpressure();
        logic [31:0] pa, echo; logic [1:0] sz; logic f; int n;
        stall_en = 1'b1;
        walk(32'h0073_4ABC, 32'h4000_0000, 4, pa, sz, f, echo, n);
        stall_en = 1'b0;
        chk("R10 reads under stall", n, 32'd2);
        chk("R10 l2 addr under stall", rd_log[(rd_total-1) & 15], 32'h5000_04D0);
        chk("R10 pa under stall", pa, 32'h7777_4ABC);
        chk("R9 iova echo", echo, 32'h0073_4ABC);
    endtask

    initial begin
        mem_tbl[32'h4000_048C] = 32'hABC0_0002;   // section
        mem_tbl[32'h4000_0014] = 32'h8000_0000;   // code 0
        mem_tbl[32'h4000_0018] = 32'h9000_0C03;   // code 3
        mem_tbl[32'h4000_001C] = 32'h5000_0401;   // table pointer
        mem_tbl[32'h1000_400C] = 32'hFED0_0002;
        for (int k = 0; k < 16; k++)
            mem_tbl[32'h5000_04C0 + 32'(k*4)] = 32'h7777_0001;
        mem_tbl[32'h5000_0484] = 32'h1234_5002;
        mem_tbl[32'h5000_0488] = 32'h2468_A003;
        mem_tbl[32'h5000_048C] = 32'hFFFF_F000;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_section();
        t_base_add();
        t_l1_fault(32'h0050_0000, "code0");
        t_l1_fault(32'h0060_1000, "code3");
        t_large(32'h0073_4ABC, 32'h5000_04D0, 32'h7777_4ABC);
        t_large(32'h0073_FFF0, 32'h5000_04FC, 32'h7777_FFF0);
        t_small(32'h0072_1234, 32'h1234_5234);
        t_small(32'h0072_2FFF, 32'h2468_AFFF);
        t_l2_fault();
        t_backpressure();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule